// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three half-bridges. One shared period counter feeds three channels. Each channel compares the count against its own duty value and produces a complementary high-side/low-side pair. A programmable gap is inserted at every switch-over of a pair, during which neither output is active. The counter either ramps up and wraps (edge-aligned) or ramps up and back down (center-aligned). In center-aligned mode the on-window of each channel is symmetric about count zero.

The period, duty and converter-trigger values are written into shadow registers. The live copies take them only when a period ends, so a new setting never cuts a pulse short. A single-cycle trigger for an analog-to-digital converter fires when the count reaches a programmable value on the rising ramp.

Three emergency-stop inputs immediately force every output to its inactive level. A static bit can instead release the output drivers through a deasserted output-enable. The fault condition is latched until software clears it with no stop input still asserted.

Top module: `tri_phase_pwm`

## Requirements
- R1: In edge mode the period is TOP+1 clocks. In center mode the count runs 0 up to TOP and back to 1, giving a period of 2*TOP clocks.
- R2: A channel's raw drive is high while count < duty. This is duty clocks per period in edge mode and 2*duty-1 clocks in center mode (1 <= duty <= TOP). A duty of 0 keeps the high side off for the whole period, and a duty above TOP keeps it on for the whole period.
- R3: At every change of a channel's raw drive, both outputs of the pair are inactive for dead_cycles+1 clocks. The high side is therefore active for (raw-high clocks - dead_cycles - 1) per period, and the low side for (raw-low clocks - dead_cycles - 1) per period.
- R4: The two outputs of a pair are never active in the same clock.
- R5: The polarity bit of each output selects its active level: 0 = active-high, 1 = active-low (the idle pin level equals the polarity bit).
- R6: TOP, the duty values and the trigger value written during a period take effect only from the start of the next period.
- R7: adc_pulse is high for one clock when count equals the trigger value while counting up, so it fires exactly once per period in both modes.
- R8: While any estop bit is high or a fault is latched, all six outputs sit at their inactive levels in the same clock. out_en is then 0 if safe_hiz is 1, and stays 1 if safe_hiz is 0.
- R9: fault rises one clock after any estop bit is high. It then stays high until a clock in which fault_clr is 1 and no estop bit is high.
- R10: During reset every output is at its inactive level and fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| center_mode | input | 1 | 1 = up/down counting, 0 = up counting with wrap |
| top_val | input | CW | Period limit (shadowed) |
| cmp_all | input | 3*CW | Duty values, channel i at bits [i*CW +: CW] (shadowed) |
| adc_at | input | CW | Count value for the converter trigger (shadowed) |
| dead_cycles | input | DW | Dead gap minus one, in clocks |
| pol_a | input | 3 | High-side polarity per channel (1 = active-low) |
| pol_b | input | 3 | Low-side polarity per channel (1 = active-low) |
| estop | input | 3 | Emergency-stop requests, any bit high trips |
| safe_hiz | input | 1 | Fault action: 1 = drop out_en, 0 = drive inactive levels |
| fault_clr | input | 1 | Clears the latched fault when no estop is high |
| pwm_a | output | 3 | High-side outputs |
| pwm_b | output | 3 | Low-side outputs |
| out_en | output | 1 | Output driver enable (0 models high impedance) |
| adc_pulse | output | 1 | Single-clock converter trigger |
| fault | output | 1 | Latched fault flag |

## Verification
The assertions take the mode, polarity, dead-gap and fault-action bits to be static while a period is being observed. They also take each stop request to be held for at least one clock edge. The stimulus changes these only at a trigger pulse and then waits three periods before measuring. Duty values in the on-time table leave both the high and the low window longer than the dead gap, except the 0 and full-duty vectors, where no switch-over happens. Only the shadowed values are changed mid-period, since that is the behaviour R6 covers.

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            center_mode,
  input  logic [CW-1:0]   top_val,
  input  logic [3*CW-1:0] cmp_all,
  input  logic [CW-1:0]   adc_at,
  input  logic [DW-1:0]   dead_cycles,
  input  logic [2:0]      pol_a,
  input  logic [2:0]      pol_b,
  input  logic [2:0]      estop,
  input  logic            safe_hiz,
  input  logic            fault_clr,
  output logic [2:0]      pwm_a,
  output logic [2:0]      pwm_b,
  output logic            out_en,
  output logic            adc_pulse,
  output logic            fault
);
  localparam int NCH = 3;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, top_s, adc_s;
  logic          up, fault_q;
  logic [NCH-1:0] raw, lv, a_act, b_act;
  logic          pe, force_off;

  // end of period: next count is 0 and shadows load
  assign pe = center_mode ? (up ? (top_s == '0 || (cnt >= top_s && cnt <= ONE)) : (cnt <= ONE))
                          : (cnt >= top_s);
  assign force_off = !rst_n || fault_q || (|estop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; up <= 1'b1; top_s <= '0; adc_s <= '0;
    end else if (pe) begin
      cnt <= '0; up <= 1'b1; top_s <= top_val; adc_s <= adc_at;
    end else if (!center_mode || (up && cnt < top_s)) begin
      cnt <= cnt + ONE;
    end else begin
      up  <= 1'b0;
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (|estop)     fault_q <= 1'b1;
    else if (fault_clr)  fault_q <= 1'b0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cmp_s;
    logic [DW-1:0] dc;

    always_ff @(posedge clk) begin
      if (!rst_n)  cmp_s <= '0;
      else if (pe) cmp_s <= cmp_all[i*CW +: CW];
    end

    assign raw[i] = cnt < cmp_s;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lv[i] <= 1'b0; dc <= '0;
      end else if (raw[i] != lv[i]) begin
        if (dc == dead_cycles) begin
          lv[i] <= raw[i]; dc <= '0;
        end else begin
          dc <= dc + DW'(1);
        end
      end else begin
        dc <= '0;
      end
    end

    assign a_act[i] = lv[i] && raw[i] && !force_off;
    assign b_act[i] = !lv[i] && !raw[i] && !force_off;

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !((pwm_a[i] ^ pol_a[i]) && (pwm_b[i] ^ pol_b[i])));
    assert_gap_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_act[i]) |-> !b_act[i]);
    assert_gap_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_act[i]) |-> !a_act[i]);
  end

  assign pwm_a     = a_act ^ pol_a;
  assign pwm_b     = b_act ^ pol_b;
  assign out_en    = !(force_off && safe_hiz);
  assign adc_pulse = (cnt == adc_s) && (up || !center_mode);
  assign fault     = fault_q;

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_s);
  assert_adc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_pulse && !pe && top_s != '0) |=> !adc_pulse);
  assert_fault_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|estop) |=> fault);
  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|estop) |-> (pwm_a == pol_a && pwm_b == pol_b));
endmodule

// File: tb/tri_phase_pwm_test.sv
module tri_phase_pwm_test;
  logic        clk = 0, rst_n = 0, center_mode = 0, safe_hiz = 0, fault_clr = 0;
  logic [11:0] top_val = 12'd9, adc_at = 12'd0;
  logic [35:0] cmp_all = '0;
  logic [7:0]  dead_cycles = 8'd1;
  logic [2:0]  pol_a = 0, pol_b = 0, estop = 0;
  logic [2:0]  pwm_a, pwm_b;
  logic        out_en, adc_pulse, fault;

  int checks = 0, fails = 0, done = 0;
  int m_per, m_ovl, k;
  int m_a[3], m_b[3];

  always #2.5 clk = ~clk;

  tri_phase_pwm uut (.clk, .rst_n, .center_mode, .top_val, .cmp_all, .adc_at, .dead_cycles,
    .pol_a, .pol_b, .estop, .safe_hiz, .fault_clr, .pwm_a, .pwm_b, .out_en, .adc_pulse, .fault);

  typedef struct packed {
    logic c; logic [11:0] top; logic [11:0] cmp; logic [7:0] dead;
    logic [2:0] pa; logic [2:0] pb; int ea; int eb; int ep;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 12'd9,  12'd4,  8'd1, 3'b000, 3'b000, 2,  4,  10},
    '{1'b0, 12'd15, 12'd8,  8'd2, 3'b101, 3'b011, 5,  5,  16},
    '{1'b0, 12'd9,  12'd0,  8'd1, 3'b000, 3'b000, 0,  10, 10},
    '{1'b0, 12'd9,  12'd12, 8'd1, 3'b000, 3'b000, 10, 0,  10},
    '{1'b1, 12'd8,  12'd3,  8'd1, 3'b000, 3'b000, 3,  9,  16},
    '{1'b1, 12'd10, 12'd5,  8'd0, 3'b110, 3'b001, 8,  10, 20},
    '{1'b0, 12'd7,  12'd3,  8'd0, 3'b000, 3'b000, 2,  4,  8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int g = 0;
    do begin @(negedge clk); g++; end while (!adc_pulse && g < 2000);
  endtask

  // starts on a pulse cycle, ends on the next pulse cycle
  task automatic measure();
    m_per = 0; m_ovl = 0;
    for (int i = 0; i < 3; i++) begin m_a[i] = 0; m_b[i] = 0; end
    do begin
      for (int i = 0; i < 3; i++) begin
        if (pwm_a[i] ^ pol_a[i]) m_a[i]++;
        if (pwm_b[i] ^ pol_b[i]) m_b[i]++;
        if ((pwm_a[i] ^ pol_a[i]) && (pwm_b[i] ^ pol_b[i])) m_ovl++;
      end
      m_per++;
      @(negedge clk);
    end while (!adc_pulse && m_per < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 pwm_a in reset", int'(pwm_a), 0);
    chk("R10 pwm_b in reset", int'(pwm_b), 0);
    chk("R10 fault in reset", int'(fault), 0);
    rst_n = 1;

    // R1 R2 R3 R4 R5: table of configurations
    foreach (VECS[v]) begin
      @(negedge clk);
      center_mode = VECS[v].c; top_val = VECS[v].top; dead_cycles = VECS[v].dead;
      cmp_all = {3{VECS[v].cmp}}; pol_a = VECS[v].pa; pol_b = VECS[v].pb;
      repeat (3) wait_pulse();
      measure();
      chk("R1 period", m_per, VECS[v].ep);
      chk("R4 overlap clocks", m_ovl, 0);
      for (int i = 0; i < 3; i++) begin
        chk("R2/R3/R5 high-side on-time", m_a[i], VECS[v].ea);
        chk("R2/R3/R5 low-side on-time", m_b[i], VECS[v].eb);
      end
    end

    // R6: new TOP written mid-period applies only to the following period
    center_mode = 0; top_val = 12'd9; cmp_all = {3{12'd4}}; dead_cycles = 8'd1;
    pol_a = 0; pol_b = 0;
    repeat (3) wait_pulse();
    top_val = 12'd19;
    measure();
    chk("R6 current period unchanged", m_per, 10);
    measure();
    chk("R6 next period uses new TOP", m_per, 20);

    // R7: trigger at count 5; high side turns on at count 2, seven clocks later
    top_val = 12'd9; adc_at = 12'd5;
    repeat (3) wait_pulse();
    k = 0;
    do begin @(negedge clk); k++; end while (!pwm_a[0] && k < 100);
    chk("R7 trigger position", k, 7);

    // R7: center mode fires once per period, on the up ramp only
    center_mode = 1; top_val = 12'd8; adc_at = 12'd3; cmp_all = {3{12'd3}};
    repeat (3) wait_pulse();
    measure();
    chk("R7 center trigger once per period", m_per, 16);

    // R8 R9: emergency stop, drive-inactive action
    center_mode = 0; top_val = 12'd9; adc_at = 0; cmp_all = {3{12'd12}};
    pol_a = 3'b010; pol_b = 3'b100;
    repeat (3) wait_pulse();
    chk("R8 high side active before stop", int'(pwm_a), 3'b101);
    estop = 3'b010; #1;
    chk("R8 pwm_a inactive at stop", int'(pwm_a), 3'b010);
    chk("R8 pwm_b inactive at stop", int'(pwm_b), 3'b100);
    chk("R8 out_en kept with safe_hiz=0", int'(out_en), 1);
    @(negedge clk);
    chk("R9 fault set", int'(fault), 1);
    estop = 0;
    @(negedge clk);
    chk("R9 fault latched", int'(fault), 1);
    chk("R8 outputs held while latched", int'(pwm_a), 3'b010);
    estop = 3'b001; fault_clr = 1;
    @(negedge clk);
    chk("R9 clear refused while stop high", int'(fault), 1);
    estop = 0;
    @(negedge clk);
    fault_clr = 0;
    chk("R9 fault cleared", int'(fault), 0);
    chk("R8 outputs resume", int'(pwm_a), 3'b101);

    // R8: high-impedance action
    safe_hiz = 1; estop = 3'b100; #1;
    chk("R8 out_en dropped with safe_hiz=1", int'(out_en), 0);
    @(negedge clk);
    estop = 0; fault_clr = 1;
    @(negedge clk);
    fault_clr = 0;
    chk("R8 out_en restored after clear", int'(out_en), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule